// File: doc/BRIEF.md
# Addressed Multi-Drop Serial Receiver

This block recovers asynchronous serial frames from a single line shared by several stations. Every frame is framed by a low start bit and a high stop bit. Between them come the payload bits, least significant first, and then one tag bit. A tag of 1 marks the frame as a station address. A tag of 0 marks it as payload. The line rests high between frames. A new frame begins when the line falls after it has been seen high.

A mode flag lets a station ignore traffic that is not meant for it. Software raises the flag with a set pulse. While the flag is up, payload frames vanish without trace. The next address frame is delivered anyway, and the hardware then lowers the flag, so every later frame is delivered. Software compares the delivered address with its own. On a mismatch it raises the flag again and the receiver skips forward to the next address frame.

Delivered frames leave on a valid/ready output. The output holds one frame. `rx_valid` stays high, with data and flags unchanged, until a cycle in which `rx_ready` is high. That cycle consumes the frame. A frame that arrives while the held frame has not been consumed is lost, and the held frame stays. The payload width is a parameter (8 by default; 9 is also supported). All bit timing counts only the cycles where `os_tick` is high, at a parameter number of ticks per bit.

Top module: `mpu_uart_rx`

## Requirements
- R1: Payload bits arrive least significant bit first after the start bit, followed by the tag bit and then the stop bit. A delivered frame shows its payload on `rx_data` and its tag on `rx_mpb`.
- R2: Out of reset, `rx_valid`, `rx_irq`, `rx_ovr` and `mp_en` are 0.
- R3: A frame that began while `mp_en` was 1 and has tag 0 is discarded. `rx_valid`, `rx_data` and `mp_en` keep their values, and no `rx_irq` or `rx_ovr` pulse occurs.
- R4: A frame with tag 1 that began while `mp_en` was 1 is delivered with an `rx_irq` pulse. `mp_en` falls in the cycle its delivery appears.
- R5: While `mp_en` is 0, every frame, whatever its tag, is delivered with a one-cycle `rx_irq` pulse. That pulse comes in the first cycle in which the new frame shows on the outputs.
- R6: A `mp_set` pulse makes `mp_en` read 1 in the next cycle. A frame already in progress is still handled under the mode that held when its start bit was accepted.
- R7: If `mp_set` is high in the same cycle that an address frame would lower `mp_en`, `mp_en` stays 1.
- R8: A start bit is rejected as a glitch if the line is high at the half-bit sample (tick OVS/2 after detection). In that case no frame is delivered.
- R9: `rx_ferr` is 1 on a delivered frame whose stop bit was sampled low. Such frames obey the same discard rules as R3 to R5. After a low stop bit, the line must be seen high before a new start is accepted.
- R10: A frame that is to be delivered while `rx_valid` is 1 and `rx_ready` is 0 is lost. In that case `rx_ovr` pulses for one cycle, there is no `rx_irq`, and the held frame is unchanged.
- R11: While `rx_valid` is 1 and `rx_ready` is 0, `rx_valid` stays 1 and `rx_data` is stable. A cycle with `rx_ready` high consumes the frame.
- R12: Bit timing advances only on cycles with `os_tick` high. Frames are received correctly whether the tick is high every cycle or every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| os_tick | input | 1 | Oversampling enable, OVS ticks per bit |
| mp_set | input | 1 | Pulse that raises the address-skip flag |
| mp_en | output | 1 | Current address-skip flag |
| rx_valid | output | 1 | A delivered frame is held |
| rx_ready | input | 1 | Consumer takes the held frame this cycle |
| rx_data | output | DATA_W | Payload of the held frame |
| rx_mpb | output | 1 | Tag bit of the held frame |
| rx_ferr | output | 1 | Stop bit of the held frame was low |
| rx_irq | output | 1 | One-cycle pulse when a frame is delivered |
| rx_ovr | output | 1 | One-cycle pulse when a frame is lost to a full output |

## Verification
Two things can land in the same cycle: the hardware lowering the skip flag when an address frame ends, and a software `mp_set`. To provoke this, the bench holds the oversampling tick high every cycle and counts the clock edges from the falling start edge up to the stop-bit sample. It then raises `mp_set` exactly in the cycle the frame completes. The frame must still be delivered, because it began in skip mode, and `mp_en` must read 1 afterwards. In a reference run without the coincident pulse, `mp_en` must read 0. The checks then go on to random traffic at half tick rate under a model of the skip and overrun rules.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2
  } rx_state_e;

  typedef struct packed {
    logic mpb;
    logic ferr;
    logic gated;
  } mpr_tag_t;
endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= 1'b1;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mpr_deser.sv
module mpr_deser
  import mpr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_s,
  input  logic              os_tick,
  input  logic              mode_now,
  output logic              frame_done,
  output logic [DATA_W-1:0] fr_data,
  output mpr_tag_t          fr_tag
);
  localparam int NBITS = DATA_W + 2;
  localparam int CW    = $clog2(OVS);
  localparam int BW    = $clog2(NBITS);
  localparam logic [CW-1:0] HALF = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] FULL = CW'(OVS - 1);
  localparam logic [BW-1:0] LAST = BW'(NBITS - 1);

  rx_state_e        state;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bidx;
  logic [NBITS-2:0] sh;
  logic [NBITS-1:0] nxt;
  logic             line_hi;
  logic             gate;

  assign nxt = {rxd_s, sh};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      bidx       <= '0;
      sh         <= '0;
      line_hi    <= 1'b0;
      gate       <= 1'b0;
      frame_done <= 1'b0;
      fr_data    <= '0;
      fr_tag     <= '0;
    end else begin
      frame_done <= 1'b0;
      if (os_tick) begin
        unique case (state)
          ST_IDLE: begin
            if (rxd_s) begin
              line_hi <= 1'b1;
            end else if (line_hi) begin
              state <= ST_START;
              cnt   <= '0;
              gate  <= mode_now;
            end
          end
          ST_START: begin
            if (cnt == HALF) begin
              cnt <= '0;
              if (rxd_s) begin
                state   <= ST_IDLE;
                line_hi <= 1'b1;
              end else begin
                state <= ST_BITS;
                bidx  <= '0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_BITS: begin
            if (cnt == FULL) begin
              cnt <= '0;
              sh  <= nxt[NBITS-1:1];
              if (bidx == LAST) begin
                state        <= ST_IDLE;
                line_hi      <= rxd_s;
                frame_done   <= 1'b1;
                fr_data      <= nxt[DATA_W-1:0];
                fr_tag.mpb   <= nxt[DATA_W];
                fr_tag.ferr  <= ~rxd_s;
                fr_tag.gated <= gate;
              end else begin
                bidx <= bidx + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mpr_mode.sv
module mpr_mode
  import mpr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mp_set,
  input  logic     frame_done,
  input  mpr_tag_t fr_tag,
  output logic     mode,
  output logic     accept
);
  logic wake;

  assign wake   = frame_done & fr_tag.gated & fr_tag.mpb;
  assign accept = frame_done & (~fr_tag.gated | fr_tag.mpb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode <= 1'b0;
    else if (mp_set) mode <= 1'b1;
    else if (wake)   mode <= 1'b0;
  end
endmodule

// File: rtl/mpr_hold.sv
module mpr_hold
  import mpr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] fr_data,
  input  mpr_tag_t          fr_tag,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_mpb,
  output logic              rx_ferr,
  output logic              rx_irq,
  output logic              rx_ovr
);
  logic room;

  assign room = ~rx_valid | rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_mpb   <= 1'b0;
      rx_ferr  <= 1'b0;
      rx_irq   <= 1'b0;
      rx_ovr   <= 1'b0;
    end else begin
      rx_irq <= 1'b0;
      rx_ovr <= 1'b0;
      if (accept && room) begin
        rx_valid <= 1'b1;
        rx_data  <= fr_data;
        rx_mpb   <= fr_tag.mpb;
        rx_ferr  <= fr_tag.ferr;
        rx_irq   <= 1'b1;
      end else if (accept) begin
        rx_ovr <= 1'b1;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mpu_uart_rx.sv
module mpu_uart_rx
  import mpr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              os_tick,
  input  logic              mp_set,
  output logic              mp_en,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_mpb,
  output logic              rx_ferr,
  output logic              rx_irq,
  output logic              rx_ovr
);
  logic              rxd_s;
  logic              frame_done;
  logic              accept;
  logic [DATA_W-1:0] fr_data;
  mpr_tag_t          fr_tag;

  mpr_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
  );

  mpr_deser #(.DATA_W(DATA_W), .OVS(OVS)) u_deser (
    .clk(clk), .rst_n(rst_n), .rxd_s(rxd_s), .os_tick(os_tick),
    .mode_now(mp_en), .frame_done(frame_done), .fr_data(fr_data),
    .fr_tag(fr_tag)
  );

  mpr_mode u_mode (
    .clk(clk), .rst_n(rst_n), .mp_set(mp_set), .frame_done(frame_done),
    .fr_tag(fr_tag), .mode(mp_en), .accept(accept)
  );

  mpr_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .accept(accept), .fr_data(fr_data),
    .fr_tag(fr_tag), .rx_ready(rx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_mpb(rx_mpb), .rx_ferr(rx_ferr),
    .rx_irq(rx_irq), .rx_ovr(rx_ovr)
  );
endmodule

// File: rtl/mpu_uart_rx_chk.sv
module mpu_uart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mp_set,
  input logic              mp_en,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_mpb,
  input logic              rx_irq,
  input logic              rx_ovr
);
  // R5
  irq_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_valid);

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R6
  set_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mp_set |=> mp_en);

  // R10
  ovr_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr |-> (rx_valid && !rx_irq));

  // R4
  wake_delivers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mp_en) |-> ((rx_irq && rx_mpb) || rx_ovr));
endmodule

bind mpu_uart_rx mpu_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mp_set(mp_set), .mp_en(mp_en),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .rx_mpb(rx_mpb), .rx_irq(rx_irq), .rx_ovr(rx_ovr)
);

// File: tb/mpu_uart_rx_tb.sv
module mpu_uart_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       os_tick = 1'b1;
  logic       mp_set = 1'b0;
  logic       rx_ready = 1'b0;
  logic       mp_en, rx_valid, rx_mpb, rx_ferr, rx_irq, rx_ovr;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  int ovr_cnt = 0;
  bit half_rate = 1'b0;
  bit finished = 1'b0;

  // bench model
  bit       m_mpie = 1'b0;
  bit       m_valid = 1'b0;
  bit [7:0] m_data = 8'h00;
  bit       m_mpb = 1'b0;
  bit       m_ferr = 1'b0;
  int       exp_irq = 0;
  int       exp_ovr = 0;

  always #4 clk = ~clk;

  mpu_uart_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
    .mp_set(mp_set), .mp_en(mp_en), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_mpb(rx_mpb),
    .rx_ferr(rx_ferr), .rx_irq(rx_irq), .rx_ovr(rx_ovr)
  );

  always @(negedge clk) os_tick <= half_rate ? ~os_tick : 1'b1;

  always @(posedge clk) begin
    if (rst_n && rx_irq) irq_cnt <= irq_cnt + 1;
    if (rst_n && rx_ovr) ovr_cnt <= ovr_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit will_accept(input bit gate, input bit mpb);
    return !gate || mpb;
  endfunction

  task automatic model_frame(input bit [7:0] d, input bit mpb, input bit stop_ok,
                             input bit gate, input bit set_won);
    if (gate && mpb && !set_won) m_mpie = 1'b0;
    if (will_accept(gate, mpb)) begin
      if (!m_valid) begin
        m_valid = 1'b1; m_data = d; m_mpb = mpb; m_ferr = !stop_ok;
        exp_irq++;
      end else begin
        exp_ovr++;
      end
    end
  endtask

  task automatic send_frame(input bit [7:0] d, input bit mpb, input bit stop_ok);
    int bc = half_rate ? 32 : 16;
    rxd = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (bc) @(negedge clk);
    end
    rxd = mpb;
    repeat (bc) @(negedge clk);
    rxd = stop_ok;
    repeat (bc) @(negedge clk);
    rxd = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    chk({req, " valid"}, int'(rx_valid), int'(m_valid));
    if (m_valid) begin
      chk({req, " data"}, int'(rx_data), int'(m_data));
      chk({req, " mpb"},  int'(rx_mpb),  int'(m_mpb));
      chk({req, " ferr"}, int'(rx_ferr), int'(m_ferr));
    end
    chk({req, " mode"}, int'(mp_en), int'(m_mpie));
    chk({req, " irq count"}, irq_cnt, exp_irq);
    chk({req, " ovr count"}, ovr_cnt, exp_ovr);
  endtask

  task automatic pop(input string req);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    m_valid = 1'b0;
    @(negedge clk);
    chk({req, " consumed"}, int'(rx_valid), 0);
  endtask

  task automatic set_mode();
    mp_set = 1'b1;
    @(negedge clk);
    mp_set = 1'b0;
    m_mpie = 1'b1;
    chk("R6 set visible", int'(mp_en), 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    // R2 reset state
    chk("R2 valid", int'(rx_valid), 0);
    chk("R2 irq", int'(rx_irq), 0);
    chk("R2 ovr", int'(rx_ovr), 0);
    chk("R2 mode", int'(mp_en), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R1 R5: normal frames, both tags
    send_frame(8'hA5, 1'b0, 1'b1); model_frame(8'hA5, 0, 1, 0, 0);
    check_all("R1 R5 data frame");
    pop("R11");
    send_frame(8'h3C, 1'b1, 1'b1); model_frame(8'h3C, 1, 1, 0, 0);
    check_all("R5 id frame no skip");
    pop("R11");

    // R3 R4: skip mode
    set_mode();
    send_frame(8'h11, 1'b0, 1'b1); model_frame(8'h11, 0, 1, 1, 0);
    check_all("R3 discarded");
    send_frame(8'h81, 1'b1, 1'b1); model_frame(8'h81, 1, 1, 1, 0);
    check_all("R4 id wakes");
    pop("R11");
    send_frame(8'h22, 1'b0, 1'b1); model_frame(8'h22, 0, 1, 0, 0);
    check_all("R4 after wake");
    pop("R11");

    // R6: set during a frame, old mode applies
    fork
      send_frame(8'h5A, 1'b0, 1'b1);
      begin
        repeat (80) @(negedge clk);
        mp_set = 1'b1;
        @(negedge clk);
        mp_set = 1'b0;
        chk("R6 mid-frame set visible", int'(mp_en), 1);
      end
    join
    m_mpie = 1'b1;
    model_frame(8'h5A, 0, 1, 0, 0);
    check_all("R6 frame under old mode");
    pop("R11");
    send_frame(8'h66, 1'b0, 1'b1); model_frame(8'h66, 0, 1, 1, 0);
    check_all("R6 next frame skipped");

    // R7: set coincides with wake
    fork
      send_frame(8'hC3, 1'b1, 1'b1);
      begin
        repeat (171) @(posedge clk);
        @(negedge clk);
        mp_set = 1'b1;
        @(negedge clk);
        mp_set = 1'b0;
      end
    join
    model_frame(8'hC3, 1, 1, 1, 1);
    check_all("R7 set wins");
    pop("R11");
    send_frame(8'h99, 1'b1, 1'b1); model_frame(8'h99, 1, 1, 1, 0);
    check_all("R7 reference wake");
    pop("R11");

    // R8: glitch
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (60) @(negedge clk);
    check_all("R8 glitch ignored");
    send_frame(8'h0F, 1'b0, 1'b1); model_frame(8'h0F, 0, 1, 0, 0);
    check_all("R8 frame after glitch");
    pop("R11");

    // R9: framing error, delivered and gated
    send_frame(8'hF0, 1'b0, 1'b0); model_frame(8'hF0, 0, 0, 0, 0);
    check_all("R9 ferr delivered");
    pop("R11");
    set_mode();
    send_frame(8'h77, 1'b0, 1'b0); model_frame(8'h77, 0, 0, 1, 0);
    check_all("R9 ferr skipped");
    send_frame(8'h42, 1'b1, 1'b0); model_frame(8'h42, 1, 0, 1, 0);
    check_all("R9 ferr id wakes");

    // R10 R11: overrun keeps older frame
    send_frame(8'h13, 1'b0, 1'b1); model_frame(8'h13, 0, 1, 0, 0);
    check_all("R10 overrun");
    chk("R11 still valid", int'(rx_valid), 1);
    pop("R11");

    // R12: half-rate ticks, random traffic
    half_rate = 1'b1;
    repeat (8) @(negedge clk);
    for (int n = 0; n < 36; n++) begin
      bit [7:0] d = 8'($urandom);
      bit mpb = ($urandom % 3) == 0;
      bit stop_ok = ($urandom % 8) != 0;
      bit gate;
      if (($urandom % 4) == 0) set_mode();
      gate = m_mpie;
      send_frame(d, mpb, stop_ok);
      model_frame(d, mpb, stop_ok, gate, 0);
      check_all("R12 random");
      if (($urandom % 3) != 0 && m_valid) pop("R11");
    end

    finish_run();
  end
endmodule